// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block switches a set of free-running clock outputs on and off without glitches. The outputs form four groups: CPU clocks, memory clocks, PCI clocks and one free-running PCI clock. Each output has its own enable bit from a control register. The block also has two active-low halt pins (one for the CPU group, one for the PCI group), a pin-sharing select, and an active-low sleep pin. The outputs come from three source clocks. The source of the PCI group also serves as the reference clock for all of the control logic.

The halt and sleep pins are asynchronous. They pass through a two-stage synchronizer in the reference domain. They are then merged with the enable bits into one registered request word, which is updated on the reference rising edge. Every output has a gate flop clocked on the falling edge of its own source clock. The gate flop takes the request, and the output is the source clock ANDed with the gate state. A start or stop therefore always waits for a reference rising edge and then a falling edge of the target clock. The output begins and ends only on whole high phases, and a stopped output rests low.

When the pin-sharing select is 0, the two top memory outputs are not available: their pins are used for the halt inputs, so those outputs are held low. When it is 1, those two outputs run normally and both halt inputs are ignored.

Top module: `clkstop_ctrl`

## Requirements
- R1: A stopped output is held at logic 0. While rst is high, every output is 0.
- R2: Every high pulse on an output lasts exactly one high phase of its source clock. No low gap between two pulses is shorter than one low phase of the source.
- R3: Suppose a pin change is first sampled at reference rising edge n. The PCI-group outputs keep their old state through the high phase that begins at edge n+2 and show the new state from the high phase that begins at edge n+3. Every other output takes the new state at the first falling edge of its own source after edge n+2.
- R4: Output i of a group runs only while bit i of that group's enable input is 1 (bit i of cpu_en_i drives cpu_clk_o[i], and likewise for mem, pci and pcifr), no applicable halt is in force, and sleep_n is 1.
- R5: With share_sel_i = 0 and cpu_halt_n = 0, all CPU outputs stop. The memory outputs keep running as their enables select.
- R6: With share_sel_i = 0 and pci_halt_n = 0, pci_clk_o[5:0] stop. pcifr_clk_o keeps running.
- R7: With share_sel_i = 1, both halt pins are ignored and mem_clk_o[7:6] follow mem_en_i[7:6]. With share_sel_i = 0, mem_clk_o[7:6] are held at 0.
- R8: With sleep_n = 0, every output is 0, including pcifr_clk_o. When sleep_n returns to 1, the outputs resume according to their enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset |
| pci_src_clk | input | 1 | PCI source clock; also the reference clock for the control logic |
| cpu_src_clk | input | 1 | CPU source clock |
| mem_src_clk | input | 1 | Memory source clock |
| share_sel_i | input | 1 | 0: halt pins active and mem outputs 7:6 unavailable; 1: halts ignored |
| cpu_halt_n | input | 1 | Active-low asynchronous halt for the CPU group |
| pci_halt_n | input | 1 | Active-low asynchronous halt for PCI outputs 5:0 |
| sleep_n | input | 1 | Active-low asynchronous power-down |
| cpu_en_i | input | 3 | Per-output enables for the CPU group |
| mem_en_i | input | 8 | Per-output enables for the memory group |
| pci_en_i | input | 6 | Per-output enables for PCI outputs 5:0 |
| pcifr_en_i | input | 1 | Enable for the free-running PCI output |
| cpu_clk_o | output | 3 | Gated CPU clocks |
| mem_clk_o | output | 8 | Gated memory clocks |
| pci_clk_o | output | 6 | Gated PCI clocks |
| pcifr_clk_o | output | 1 | Free-running PCI clock; stopped only by its enable or by sleep |

## Verification
The assertions rely on three assumptions about the inputs. The source clocks are related and never place a CPU or memory falling edge on a reference rising edge. The enable bits change only away from reference rising edges. rst is held across several edges of every source. The stimulus meets these assumptions as follows. The CPU and memory sources run at exactly twice the reference rate, and their rising edges line up with the reference rising edges. Every input change is made 4 ns after a reference rising edge. Outputs are sampled at that same point, when all sources are high, so a running output reads 1 and a stopped one reads 0.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int CPU_N      = 3;
    localparam int MEM_N      = 8;
    localparam int PCI_N      = 6;
    localparam int SYNC_DEPTH = 2;
    localparam int SHARED_N   = 2;   // top memory outputs that share pins with the halt inputs

    // one bit per output, used both for enables and for requests
    typedef struct packed {
        logic [CPU_N-1:0] cpu;
        logic [MEM_N-1:0] mem;
        logic [PCI_N-1:0] pci;
        logic             pcifr;
    } clkset_t;

    // synchronized pin state, all active high
    typedef struct packed {
        logic share;
        logic cpu_run;
        logic pci_run;
        logic awake;
    } pinctl_t;

    localparam int PIN_W = $bits(pinctl_t);

    function automatic logic [MEM_N-1:0] mem_pin_mask(input logic share);
        logic [MEM_N-1:0] m;
        m = '1;
        if (!share) m[MEM_N-1 -: SHARED_N] = '0;
        return m;
    endfunction

    function automatic clkset_t grant(input clkset_t en, input pinctl_t c);
        clkset_t g;
        logic cpu_go, pci_go;
        cpu_go  = (c.share | c.cpu_run) & c.awake;
        pci_go  = (c.share | c.pci_run) & c.awake;
        g.cpu   = en.cpu & {CPU_N{cpu_go}};
        g.mem   = en.mem & mem_pin_mask(c.share) & {MEM_N{c.awake}};
        g.pci   = en.pci & {PCI_N{pci_go}};
        g.pcifr = en.pcifr & c.awake;
        return g;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clkstop_req.sv
module clkstop_req
    import clkstop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    share_raw,
    input  logic    cpu_run_raw,
    input  logic    pci_run_raw,
    input  logic    awake_raw,
    input  clkset_t en_i,
    output clkset_t req_o,
    output pinctl_t ctl_o
);
    pinctl_t ctl_s;
    clkset_t req_q;

    clkstop_sync #(.W(PIN_W), .STAGES(SYNC_DEPTH), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({share_raw, cpu_run_raw, pci_run_raw, awake_raw}),
        .q_o (ctl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= grant(en_i, ctl_s);
    end

    assign req_o = req_q;
    assign ctl_o = ctl_s;

    // R5
    cpu_halt_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!ctl_s.share) && $past(!ctl_s.cpu_run)) |-> (req_q.cpu == '0));

    // R5
    mem_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_s.awake) && $past(!ctl_s.cpu_run))
            |-> (req_q.mem[MEM_N-SHARED_N-1:0] == $past(en_i.mem[MEM_N-SHARED_N-1:0])));

    // R7
    shared_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!ctl_s.share) |-> (req_q.mem[MEM_N-1 -: SHARED_N] == '0));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int W = 1
) (
    input  logic         src_i,
    input  logic         rst,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] clk_o
);
    logic [W-1:0] en_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // gate state moves only while the source is low
        always_ff @(negedge src_i) begin
            if (rst) en_q[i] <= 1'b0;
            else     en_q[i] <= req_i[i];
        end

        assign clk_o[i] = src_i & en_q[i];

        // R1
        rest_low_chk: assert property (@(negedge src_i) disable iff (rst)
            !$past(req_i[i]) |-> !clk_o[i]);

        // R2
        always @(en_q[i]) begin
            gate_edge_chk: assert (!src_i);
        end
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
(
    input  logic             rst,
    input  logic             pci_src_clk,
    input  logic             cpu_src_clk,
    input  logic             mem_src_clk,
    input  logic             share_sel_i,
    input  logic             cpu_halt_n,
    input  logic             pci_halt_n,
    input  logic             sleep_n,
    input  logic [CPU_N-1:0] cpu_en_i,
    input  logic [MEM_N-1:0] mem_en_i,
    input  logic [PCI_N-1:0] pci_en_i,
    input  logic             pcifr_en_i,
    output logic [CPU_N-1:0] cpu_clk_o,
    output logic [MEM_N-1:0] mem_clk_o,
    output logic [PCI_N-1:0] pci_clk_o,
    output logic             pcifr_clk_o
);
    clkset_t en_set, req;
    pinctl_t ctl;
    logic [PCI_N:0] pci_bank_o;

    assign en_set = '{cpu: cpu_en_i, mem: mem_en_i, pci: pci_en_i, pcifr: pcifr_en_i};

    clkstop_req u_req (
        .clk         (pci_src_clk),
        .rst         (rst),
        .share_raw   (share_sel_i),
        .cpu_run_raw (cpu_halt_n),
        .pci_run_raw (pci_halt_n),
        .awake_raw   (sleep_n),
        .en_i        (en_set),
        .req_o       (req),
        .ctl_o       (ctl)
    );

    clkstop_gate #(.W(CPU_N)) u_cpu_gate (
        .src_i (cpu_src_clk), .rst (rst), .req_i (req.cpu), .clk_o (cpu_clk_o)
    );

    clkstop_gate #(.W(MEM_N)) u_mem_gate (
        .src_i (mem_src_clk), .rst (rst), .req_i (req.mem), .clk_o (mem_clk_o)
    );

    clkstop_gate #(.W(PCI_N+1)) u_pci_gate (
        .src_i (pci_src_clk), .rst (rst), .req_i ({req.pci, req.pcifr}), .clk_o (pci_bank_o)
    );

    assign pci_clk_o   = pci_bank_o[PCI_N:1];
    assign pcifr_clk_o = pci_bank_o[0];

    // R8
    sleep_off_chk: assert property (@(negedge pci_src_clk) disable iff (rst)
        (!ctl.awake && $past(!ctl.awake) && $past(!ctl.awake, 2))
            |-> (pci_clk_o == '0 && !pcifr_clk_o));

    // R6
    pci_halt_chk: assert property (@(negedge pci_src_clk) disable iff (rst)
        ((!ctl.share && !ctl.pci_run) && $past(!ctl.share && !ctl.pci_run)
            && $past(!ctl.share && !ctl.pci_run, 2)) |-> (pci_clk_o == '0));
endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps

module clkstop_pulse_mon #(
    parameter int     W    = 1,
    parameter longint HALF = 8
) (
    input  logic [W-1:0] sig,
    output logic [W-1:0] bad
);
    for (genvar i = 0; i < W; i++) begin : g_mon
        longint t_edge = 0;
        logic   seen   = 1'b0;
        logic   b      = 1'b0;
        always @(sig[i]) begin
            if (seen) begin
                if (sig[i]) begin
                    if (($time - t_edge) < HALF) b = 1'b1;
                end else begin
                    if (($time - t_edge) != HALF) b = 1'b1;
                end
            end
            seen   = 1'b1;
            t_edge = $time;
        end
        assign bad[i] = b;
    end
endmodule

module clkstop_ctrl_test;
    localparam int     CLK_PERIOD = 32;              // reference (PCI source) period
    localparam int     FAST_HALF  = CLK_PERIOD / 4;  // CPU/mem sources run at twice the rate
    localparam int     NVEC       = 9;

    // stimulus: {share, cpu_halt_n, pci_halt_n, sleep_n, cpu_en[2:0], mem_en[7:0], pci_en[5:0], pcifr_en}
    localparam logic [21:0] STIM [NVEC] = '{
        {1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b1, 3'b101, 8'hA5, 6'h2A, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'b010, 8'h5A, 6'h15, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 3'b111, 8'hFF, 6'h3F, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 8'hFF, 6'h3F, 1'b1}
    };
    // expected level at the sample point: {cpu[2:0], mem[7:0], pci[5:0], pcifr}
    localparam logic [17:0] EXPV [NVEC] = '{
        {3'b111, 8'hFF, 6'h3F, 1'b1},
        {3'b111, 8'hFF, 6'h3F, 1'b1},
        {3'b000, 8'h3F, 6'h3F, 1'b1},
        {3'b111, 8'h3F, 6'h00, 1'b1},
        {3'b000, 8'h3F, 6'h00, 1'b1},
        {3'b101, 8'h25, 6'h2A, 1'b0},
        {3'b010, 8'h5A, 6'h15, 1'b1},
        {3'b000, 8'h00, 6'h00, 1'b0},
        {3'b000, 8'h00, 6'h00, 1'b0}
    };

    logic       rst, pci_src, cpu_src, mem_src;
    logic       share, cpu_halt_n, pci_halt_n, sleep_n, pcifr_en;
    logic [2:0] cpu_en, cpu_clk;
    logic [7:0] mem_en, mem_clk;
    logic [5:0] pci_en, pci_clk;
    logic       pcifr_clk;
    logic [2:0] cpu_bad;
    logic [7:0] mem_bad;
    logic [6:0] pci_bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string vtag [NVEC];

    clkstop_ctrl uut (
        .rst (rst), .pci_src_clk (pci_src), .cpu_src_clk (cpu_src), .mem_src_clk (mem_src),
        .share_sel_i (share), .cpu_halt_n (cpu_halt_n), .pci_halt_n (pci_halt_n),
        .sleep_n (sleep_n), .cpu_en_i (cpu_en), .mem_en_i (mem_en), .pci_en_i (pci_en),
        .pcifr_en_i (pcifr_en), .cpu_clk_o (cpu_clk), .mem_clk_o (mem_clk),
        .pci_clk_o (pci_clk), .pcifr_clk_o (pcifr_clk)
    );

    clkstop_pulse_mon #(.W(3), .HALF(FAST_HALF))     u_mon_cpu (.sig(cpu_clk), .bad(cpu_bad));
    clkstop_pulse_mon #(.W(8), .HALF(FAST_HALF))     u_mon_mem (.sig(mem_clk), .bad(mem_bad));
    clkstop_pulse_mon #(.W(7), .HALF(CLK_PERIOD/2))  u_mon_pci (.sig({pci_clk, pcifr_clk}), .bad(pci_bad));

    // rising edges of all three sources coincide
    initial begin
        pci_src = 1'b0;
        #(CLK_PERIOD/2);
        forever begin pci_src = 1'b1; #(CLK_PERIOD/2); pci_src = 1'b0; #(CLK_PERIOD/2); end
    end
    initial begin
        cpu_src = 1'b0;
        #(CLK_PERIOD/2);
        forever begin cpu_src = 1'b1; #(FAST_HALF); cpu_src = 1'b0; #(FAST_HALF); end
    end
    initial begin
        mem_src = 1'b0;
        #(CLK_PERIOD/2);
        forever begin mem_src = 1'b1; #(FAST_HALF); mem_src = 1'b0; #(FAST_HALF); end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int k);
        {share, cpu_halt_n, pci_halt_n, sleep_n, cpu_en, mem_en, pci_en, pcifr_en} = STIM[k];
    endtask

    // land 4 ns after a reference rising edge: every source is high there
    task automatic to_sample();
        @(posedge pci_src);
        #4;
    endtask

    task automatic chk_groups(input string tag, input logic [17:0] exp);
        chk(tag, "cpu",   {29'd0, cpu_clk},   {29'd0, exp[17:15]});
        chk(tag, "mem",   {24'd0, mem_clk},   {24'd0, exp[14:7]});
        chk(tag, "pci",   {26'd0, pci_clk},   {26'd0, exp[6:1]});
        chk(tag, "pcifr", {31'd0, pcifr_clk}, {31'd0, exp[0]});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vtag = '{"R4", "R7", "R5", "R6", "R5", "R4", "R7", "R8", "R8"};
        rst = 1'b1;
        apply(0);
        repeat (5) to_sample();
        // R1: everything low while reset is held
        chk("R1", "all outputs in reset", {14'd0, cpu_clk, mem_clk, pci_clk, pcifr_clk}, 32'd0);
        to_sample();
        rst = 1'b0;

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            apply(k);
            repeat (5) to_sample();
            chk_groups(vtag[k], EXPV[k]);
        end

        // R8: wake from sleep, all enabled
        apply(0);
        repeat (5) to_sample();
        chk_groups("R8", EXPV[0]);

        // R3: exact stop latency, both halts in shared mode
        share = 1'b0;
        repeat (5) to_sample();
        cpu_halt_n = 1'b0;
        pci_halt_n = 1'b0;
        repeat (3) to_sample();                        // high phase of edge n+2
        chk("R3", "cpu before stop", {29'd0, cpu_clk}, 32'h7);
        chk("R3", "pci before stop", {26'd0, pci_clk}, 32'h3F);
        to_sample();                                   // high phase of edge n+3
        chk("R3", "cpu stopped", {29'd0, cpu_clk}, 32'h0);
        chk("R3", "pci stopped", {26'd0, pci_clk}, 32'h0);
        chk("R5", "mem keeps running", {24'd0, mem_clk}, 32'h3F);
        chk("R6", "pcifr keeps running", {31'd0, pcifr_clk}, 32'h1);

        // R3: exact restart latency
        cpu_halt_n = 1'b1;
        pci_halt_n = 1'b1;
        repeat (3) to_sample();
        chk("R3", "cpu before restart", {29'd0, cpu_clk}, 32'h0);
        chk("R3", "pci before restart", {26'd0, pci_clk}, 32'h0);
        to_sample();
        chk("R3", "cpu restarted", {29'd0, cpu_clk}, 32'h7);
        chk("R3", "pci restarted", {26'd0, pci_clk}, 32'h3F);

        // R7: shared memory outputs follow their enables once sharing is released
        share  = 1'b1;
        mem_en = 8'hC0;
        repeat (5) to_sample();
        chk("R7", "shared mem pair", {24'd0, mem_clk}, 32'hC0);

        // R2: no short pulse anywhere during the whole run
        to_sample();
        chk("R2", "cpu pulse widths", {29'd0, cpu_bad}, 32'd0);
        chk("R2", "mem pulse widths", {24'd0, mem_bad}, 32'd0);
        chk("R2", "pci pulse widths", {25'd0, pci_bad}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule